// File: doc/BRIEF.md
# Programmable CRT Display Timing Generator

This block turns a small bank of programmed timing registers into the raster control signals of a CRT-style display: horizontal sync, vertical sync, display enable and blanking. It also exposes the current character column, the current scan line and a row pitch value. One clock cycle is one character clock of 8 pixels, so horizontal positions are counted in characters and vertical positions in scan lines.

Software writes the registers through a single-cycle index/data port. Most fields hold biased values: the horizontal total is stored as characters minus 5, the vertical total as lines minus 2, and display ends as counts minus 1. The sync end fields are short, so a sync pulse ends when the low bits of the counter match the field. A protect bit locks the basic horizontal registers. Writes go to a pending copy, and that copy is moved into the active copy at the wrap from the last column of the last line. A frame already in progress therefore always finishes with the settings it started with.

Each axis is a four-state phase machine: DISP (display region), FRONT (front porch), SYNC (sync pulse) and BACK (back porch). These are the transitions:
- DISP goes to FRONT after the display end, or straight to SYNC if the sync starts at the very next position.
- FRONT goes to SYNC where the sync start falls.
- SYNC goes to BACK when the sync end matches.
- The total wrap returns any state to DISP.
- The vertical machine moves only on the last column of a line.

Top module: `crtc_timing_gen`

## Requirements
- R1: `char_col` counts 0 up to (field at index 0x00, with bit 8 from index 0x38 bit 0) + 4, then wraps to 0. `scan_line` advances by one only on that wrap.
- R2: Horizontally, columns 0 up to the value at index 0x01 are the display region.
- R3: `hsync` is high from the column equal to index 0x04. It falls at the first later column whose low 5 bits equal index 0x05 bits 4:0.
- R4: `scan_line` counts 0 up to (index 0x06, with bits 11:8 from index 0x30 bits 3:0) + 1, then wraps to 0 together with the column wrap.
- R5: `vsync` is high from line (index 0x10, with bits 11:8 from index 0x32 bits 3:0) + 1. It falls at the first later line whose low 4 bits equal index 0x11 bits 3:0 plus 1, modulo 16.
- R6: Vertically, lines 0 up to (index 0x12, with bits 11:8 from index 0x31 bits 3:0) are the display region.
- R7: `disp_en` is high only when both axes are in their display regions. `blank` is its inverse. Both syncs are active high and never high while `disp_en` is high.
- R8: While index 0x11 bit 7 is 1, writes to indices 0x00 to 0x07 are ignored. Writing index 0x11 with bit 7 at 0 removes the protection.
- R9: `row_pitch` equals {index 0x41 bits 3:0, index 0x13} in 8-byte units.
- R10: Written values take effect at column 0 of line 0 of the next frame. Outputs during the current frame keep the old settings.
- R11: After reset, both counters are 0, protection is off, and the settings are the 640x480 frame: 100 character total, 80 displayed, sync at 82 to 94, 525 lines, 480 displayed, vsync lines 490 to 491, pitch 80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 8 | Register index |
| wr_data | input | 8 | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | Display enable |
| blank | output | 1 | Blanking, inverse of display enable |
| char_col | output | 9 | Current character column |
| scan_line | output | 12 | Current scan line |
| row_pitch | output | 12 | Active row pitch in 8-byte units |

## Verification
The assertions assume the programmed values keep their natural order on each axis: the display end comes before the sync start, the sync end matches before the total wrap, and the total is at least a few positions long. Outside that order the phase machines still run, but the sync-versus-display relation is not meaningful. The stimulus keeps to this rule. It uses three settings (the reset frame, a tiny frame, and a mid-size frame whose sync end crosses a 32-column boundary). It writes new values only while a frame is in progress.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
    localparam int REG_W   = 8;
    localparam int COL_W   = 9;
    localparam int LINE_W  = 12;
    localparam int PITCH_W = 12;
    localparam int HSE_W   = 5;
    localparam int VSE_W   = 4;
    localparam int HTOT_BIAS = 5;
    localparam int VTOT_BIAS = 2;

    localparam logic [REG_W-1:0] IDX_HTOT_LO  = 8'h00;
    localparam logic [REG_W-1:0] IDX_HDISP    = 8'h01;
    localparam logic [REG_W-1:0] IDX_HSYNC_ON = 8'h04;
    localparam logic [REG_W-1:0] IDX_HSYNC_OF = 8'h05;
    localparam logic [REG_W-1:0] IDX_VTOT_LO  = 8'h06;
    localparam logic [REG_W-1:0] IDX_PROT_TOP = 8'h07;
    localparam logic [REG_W-1:0] IDX_VSYNC_LO = 8'h10;
    localparam logic [REG_W-1:0] IDX_VSE_PROT = 8'h11;
    localparam logic [REG_W-1:0] IDX_VDISP_LO = 8'h12;
    localparam logic [REG_W-1:0] IDX_PITCH_LO = 8'h13;
    localparam logic [REG_W-1:0] IDX_VTOT_HI  = 8'h30;
    localparam logic [REG_W-1:0] IDX_VDISP_HI = 8'h31;
    localparam logic [REG_W-1:0] IDX_VSYNC_HI = 8'h32;
    localparam logic [REG_W-1:0] IDX_HTOT_HI  = 8'h38;
    localparam logic [REG_W-1:0] IDX_PITCH_HI = 8'h41;

    typedef enum logic [1:0] {
        PH_DISP  = 2'd0,
        PH_FRONT = 2'd1,
        PH_SYNC  = 2'd2,
        PH_BACK  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [COL_W-1:0]   htot;
        logic [REG_W-1:0]   hde;
        logic [REG_W-1:0]   hss;
        logic [HSE_W-1:0]   hse;
        logic [LINE_W-1:0]  vtot;
        logic [LINE_W-1:0]  vde;
        logic [LINE_W-1:0]  vss;
        logic [VSE_W-1:0]   vse;
        logic [PITCH_W-1:0] pitch;
    } crtc_cfg_t;

    localparam crtc_cfg_t CFG_RESET = '{
        htot:  9'd95,
        hde:   8'd79,
        hss:   8'd82,
        hse:   5'd30,
        vtot:  12'd523,
        vde:   12'd479,
        vss:   12'd489,
        vse:   4'd11,
        pitch: 12'd80
    };
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
    import crtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic             frame_load,
    output crtc_cfg_t        cfg_act
);
    crtc_cfg_t pend;
    logic      prot;
    logic      wr_ok;

    assign wr_ok = wr_en && !(prot && (wr_idx <= IDX_PROT_TOP));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= CFG_RESET;
            prot    <= 1'b0;
            cfg_act <= CFG_RESET;
        end else begin
            if (wr_ok) begin
                case (wr_idx)
                    IDX_HTOT_LO:  pend.htot[REG_W-1:0]      <= wr_data;
                    IDX_HTOT_HI:  pend.htot[COL_W-1]        <= wr_data[0];
                    IDX_HDISP:    pend.hde                  <= wr_data;
                    IDX_HSYNC_ON: pend.hss                  <= wr_data;
                    IDX_HSYNC_OF: pend.hse                  <= wr_data[HSE_W-1:0];
                    IDX_VTOT_LO:  pend.vtot[REG_W-1:0]      <= wr_data;
                    IDX_VTOT_HI:  pend.vtot[LINE_W-1:REG_W] <= wr_data[LINE_W-REG_W-1:0];
                    IDX_VDISP_LO: pend.vde[REG_W-1:0]       <= wr_data;
                    IDX_VDISP_HI: pend.vde[LINE_W-1:REG_W]  <= wr_data[LINE_W-REG_W-1:0];
                    IDX_VSYNC_LO: pend.vss[REG_W-1:0]       <= wr_data;
                    IDX_VSYNC_HI: pend.vss[LINE_W-1:REG_W]  <= wr_data[LINE_W-REG_W-1:0];
                    IDX_VSE_PROT: begin
                        pend.vse <= wr_data[VSE_W-1:0];
                        prot     <= wr_data[REG_W-1];
                    end
                    IDX_PITCH_LO: pend.pitch[REG_W-1:0]       <= wr_data;
                    IDX_PITCH_HI: pend.pitch[PITCH_W-1:REG_W] <= wr_data[PITCH_W-REG_W-1:0];
                    default: ;
                endcase
            end
            if (frame_load) begin
                cfg_act <= pend;
            end
        end
    end
endmodule

// File: rtl/crtc_hphase.sv
module crtc_hphase
    import crtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COL_W-1:0] tot_field,
    input  logic [REG_W-1:0] disp_end,
    input  logic [REG_W-1:0] sync_start,
    input  logic [HSE_W-1:0] sync_end_lo,
    output logic [COL_W-1:0] col,
    output logic             line_end,
    output phase_e           phase
);
    localparam logic [COL_W:0] LAST_OFS = (COL_W+1)'(HTOT_BIAS - 1);

    logic [COL_W:0]   last_col;
    logic [COL_W-1:0] col_inc;
    logic             sync_next;
    phase_e           nxt;

    assign last_col  = {1'b0, tot_field} + LAST_OFS;
    assign col_inc   = col + 1'b1;
    assign line_end  = ({1'b0, col} == last_col);
    assign sync_next = (col_inc == COL_W'(sync_start));

    always_comb begin
        nxt = phase;
        if (line_end) begin
            nxt = PH_DISP;
        end else begin
            unique case (phase)
                PH_DISP:  if (col == COL_W'(disp_end)) nxt = sync_next ? PH_SYNC : PH_FRONT;
                PH_FRONT: if (sync_next) nxt = PH_SYNC;
                PH_SYNC:  if (col_inc[HSE_W-1:0] == sync_end_lo) nxt = PH_BACK;
                PH_BACK:  nxt = PH_BACK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_DISP;
            col   <= '0;
        end else begin
            phase <= nxt;
            col   <= line_end ? '0 : col_inc;
        end
    end
endmodule

// File: rtl/crtc_vphase.sv
module crtc_vphase
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [LINE_W-1:0] tot_field,
    input  logic [LINE_W-1:0] disp_end,
    input  logic [LINE_W-1:0] sync_before,
    input  logic [VSE_W-1:0]  sync_end_lo,
    output logic [LINE_W-1:0] line,
    output logic              frame_end,
    output phase_e            phase
);
    localparam logic [LINE_W:0] LAST_OFS = (LINE_W+1)'(VTOT_BIAS - 1);

    logic [LINE_W:0] last_line;
    logic            at_last;
    phase_e          nxt;

    assign last_line = {1'b0, tot_field} + LAST_OFS;
    assign at_last   = ({1'b0, line} == last_line);
    assign frame_end = adv && at_last;

    always_comb begin
        nxt = phase;
        if (frame_end) begin
            nxt = PH_DISP;
        end else if (adv) begin
            unique case (phase)
                PH_DISP:  if (line == disp_end) nxt = (line == sync_before) ? PH_SYNC : PH_FRONT;
                PH_FRONT: if (line == sync_before) nxt = PH_SYNC;
                PH_SYNC:  if (line[VSE_W-1:0] == sync_end_lo) nxt = PH_BACK;
                PH_BACK:  nxt = PH_BACK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_DISP;
            line  <= '0;
        end else begin
            phase <= nxt;
            if (frame_end)  line <= '0;
            else if (adv)   line <= line + 1'b1;
        end
    end
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
    import crtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_idx,
    input  logic [REG_W-1:0]   wr_data,
    output logic               hsync,
    output logic               vsync,
    output logic               disp_en,
    output logic               blank,
    output logic [COL_W-1:0]   char_col,
    output logic [LINE_W-1:0]  scan_line,
    output logic [PITCH_W-1:0] row_pitch
);
    crtc_cfg_t cfg;
    phase_e    h_ph;
    phase_e    v_ph;
    logic      line_end;
    logic      frame_end;

    crtc_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .frame_load (frame_end),
        .cfg_act    (cfg)
    );

    crtc_hphase u_h (
        .clk         (clk),
        .rst_n       (rst_n),
        .tot_field   (cfg.htot),
        .disp_end    (cfg.hde),
        .sync_start  (cfg.hss),
        .sync_end_lo (cfg.hse),
        .col         (char_col),
        .line_end    (line_end),
        .phase       (h_ph)
    );

    crtc_vphase u_v (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (line_end),
        .tot_field   (cfg.vtot),
        .disp_end    (cfg.vde),
        .sync_before (cfg.vss),
        .sync_end_lo (cfg.vse),
        .line        (scan_line),
        .frame_end   (frame_end),
        .phase       (v_ph)
    );

    always_comb begin
        hsync     = (h_ph == PH_SYNC);
        vsync     = (v_ph == PH_SYNC);
        disp_en   = (h_ph == PH_DISP) && (v_ph == PH_DISP);
        blank     = !disp_en;
        row_pitch = cfg.pitch;
    end
endmodule

// File: rtl/crtc_timing_gen_chk.sv
module crtc_timing_gen_chk
    import crtc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               hsync,
    input logic               vsync,
    input logic               disp_en,
    input logic [COL_W-1:0]   char_col,
    input logic [LINE_W-1:0]  scan_line,
    input logic [PITCH_W-1:0] row_pitch
);
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (char_col != '0) |-> (char_col == $past(char_col) + 1'b1)); // R1
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (char_col != '0) |-> $stable(scan_line)); // R1
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (char_col == '0 && scan_line != '0) |-> (scan_line == $past(scan_line) + 1'b1)); // R4
    AST_DE_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (!hsync && !vsync)); // R7
    AST_PITCH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (char_col != '0 || scan_line != '0) |-> $stable(row_pitch)); // R10
endmodule

bind crtc_timing_gen crtc_timing_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync     (hsync),
    .vsync     (vsync),
    .disp_en   (disp_en),
    .char_col  (char_col),
    .scan_line (scan_line),
    .row_pitch (row_pitch)
);

// File: tb/crtc_timing_gen_tb.sv
module crtc_timing_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic        hsync, vsync, disp_en, blank;
    logic [8:0]  char_col;
    logic [11:0] scan_line;
    logic [11:0] row_pitch;

    crtc_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .blank(blank),
        .char_col(char_col), .scan_line(scan_line), .row_pitch(row_pitch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { int kind; int col; int line; } ev_t;
    typedef struct { int ht; int hd; int hs; int he; int vt; int vd; int vs; int ve; } tcfg_t;

    ev_t exp_q[$];
    int  n_chk = 0;
    int  n_fail = 0;
    bit  mon_on = 1'b0;
    bit  done = 1'b0;
    bit  m_hs, m_vs, m_de;
    bit  o_hs, o_vs, o_de;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_ev(input int kind, input int c, input int l);
        ev_t e;
        e.kind = kind; e.col = c; e.line = l;
        exp_q.push_back(e);
    endtask

    // expected edge list for one frame, derived from the requirement text
    task automatic push_frame(input tcfg_t t);
        int hlast = t.ht + 4;
        int vlast = t.vt + 1;
        int hend  = t.hs + 1;
        int vs0   = t.vs + 1;
        int vend  = vs0 + 1;
        while ((hend % 32) != t.he) hend++;
        while ((vend % 16) != ((t.ve + 1) % 16)) vend++;
        for (int l = 0; l <= vlast; l++) begin
            for (int c = 0; c <= hlast; c++) begin
                bit hs = (c >= t.hs) && (c < hend);
                bit vs = (l >= vs0) && (l < vend);
                bit de = (c <= t.hd) && (l <= t.vd);
                if (hs != m_hs) push_ev(hs ? 0 : 1, c, l);
                if (vs != m_vs) push_ev(vs ? 2 : 3, c, l);
                if (de != m_de) push_ev(de ? 4 : 5, c, l);
                m_hs = hs; m_vs = vs; m_de = de;
            end
        end
    endtask

    task automatic take_ev(input int kind, input string req);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, req, kind, -1);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == kind, req, kind, e.kind);
            check(e.col == int'(char_col), req, int'(char_col), e.col);
            check(e.line == int'(scan_line), req, int'(scan_line), e.line);
        end
    endtask

    // monitor: pops one expected item per observed edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (hsync != o_hs) take_ev(hsync ? 0 : 1, "R1,R3");
            if (vsync != o_vs) take_ev(vsync ? 2 : 3, "R4,R5");
            if (disp_en != o_de) begin
                take_ev(disp_en ? 4 : 5, "R2,R6,R7");
                check(blank == !disp_en, "R7 blank", int'(blank), int'(!disp_en));
            end
            o_hs = hsync; o_vs = vsync; o_de = disp_en;
        end
    end

    task automatic wr(input logic [7:0] idx, input logic [7:0] dat);
        wr_en = 1'b1; wr_idx = idx; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (!(char_col == 0 && scan_line == 0));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        tcfg_t cdef = '{95, 79, 82, 30, 523, 479, 489, 11};
        tcfg_t cb   = '{15, 9, 12, 15, 12, 5, 7, 9};
        tcfg_t cc   = '{35, 19, 30, 2, 268, 260, 263, 9};

        repeat (3) @(negedge clk);
        // R11 reset state
        check(char_col == 0, "R11 col", int'(char_col), 0);
        check(scan_line == 0, "R11 line", int'(scan_line), 0);
        check(!hsync && !vsync, "R11 syncs", int'({hsync, vsync}), 0);
        check(disp_en && !blank, "R11 de", int'(disp_en), 1);
        check(row_pitch == 12'd80, "R11 pitch", int'(row_pitch), 80);

        m_hs = 0; m_vs = 0; m_de = 1;
        push_frame(cdef);
        for (int i = 0; i < 3; i++) push_frame(cb);
        for (int i = 0; i < 2; i++) push_frame(cc);
        o_hs = 0; o_vs = 0; o_de = 1;
        mon_on = 1'b1;
        rst_n = 1'b1;

        repeat (5) @(negedge clk);
        wr(8'h00, 8'd15); wr(8'h38, 8'h00); wr(8'h01, 8'd9);
        wr(8'h04, 8'd12); wr(8'h05, 8'd15);
        wr(8'h06, 8'd12); wr(8'h30, 8'h00);
        wr(8'h12, 8'd5);  wr(8'h31, 8'h00);
        wr(8'h10, 8'd7);  wr(8'h32, 8'h00);
        wr(8'h11, 8'h89);                    // vse 9, protection on (R8)
        wr(8'h13, 8'h34); wr(8'h41, 8'h02);
        wr(8'h00, 8'h60); wr(8'h04, 8'h01); wr(8'h05, 8'h1f);   // ignored (R8)
        check(row_pitch == 12'd80, "R10 pitch held", int'(row_pitch), 80);

        wait_frame();
        check(row_pitch == 12'h234, "R9 pitch", int'(row_pitch), 'h234);
        do @(negedge clk); while (!hsync);
        check(char_col == 12, "R8 protected hsync start", int'(char_col), 12);

        wait_frame();
        wait_frame();
        do @(negedge clk); while (scan_line != 1);
        wr(8'h11, 8'h09);                    // protection off (R8)
        wr(8'h00, 8'd35); wr(8'h01, 8'd19);
        wr(8'h04, 8'd30); wr(8'h05, 8'd2);
        wr(8'h06, 8'h0C); wr(8'h30, 8'h01);
        wr(8'h12, 8'h04); wr(8'h31, 8'h01);
        wr(8'h10, 8'h07); wr(8'h32, 8'h01);
        wr(8'h13, 8'h99); wr(8'h41, 8'h01);
        check(row_pitch == 12'h234, "R10 pitch mid-frame", int'(row_pitch), 'h234);

        wait_frame();
        check(row_pitch == 12'h199, "R9 R10 new pitch", int'(row_pitch), 'h199);

        wait (exp_q.size() == 0);
        mon_on = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R10 all edges seen", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule